// File: doc/BRIEF.md
# Symmetric Linear-Phase Low-Pass FIR Filter

This block is a streaming 13-tap low-pass FIR filter for signed fixed-point samples. The coefficient set is mirrored about the centre tap, so each pair of samples that share a coefficient is summed first and then multiplied once. Seven multipliers therefore do the work of thirteen: six for the mirrored pairs and one for the centre sample.

Each coefficient has its own slice. A slice holds a pre-adder, a multiplier and an adder that extends a running sum passed along from the previous slice. A register can be placed after each of these three stages, which keeps the longest combinational path to a single operation. Samples enter with a valid strobe. A result leaves with its own strobe after a fixed number of cycles. The full-precision sum is rounded back to the sample format and clamped to its range.

Top module: `symfir_lp`

## Requirements
- R1: A synchronous reset empties the sample history and every pipeline register. While reset is applied, and after it until the next result is due, `out_valid` is 0 and `dout` is 0. Samples still in flight when reset arrives produce no output.
- R2: Each sample accepted with `in_valid` high yields exactly one result. `out_valid` is high exactly LAT-1 rising edges after the edge that accepts the sample, where LAT = 2 + PRE_REG + MUL_REG + 7*ACC_REG. LAT is 11 with the defaults. No other strobes occur.
- R3: With h_k = c_min(k,12-k), the result for sample n is the sum over k = 0..12 of h_k * x[n-k]. This is computed as the six pre-added pairs c_k*(x[n-k] + x[n-12+k]) plus c6*x[n-6]. The defaults for c0..c6 (outer tap to centre) are -18, -47, -21, 106, 520, 980, 1010, in units of 2^-12.
- R4: `din` and `dout` are 20-bit two's-complement values with 12 fractional bits.
- R5: The full-precision sum is scaled by 2^-12 and rounded half toward plus infinity. The rounded value is floor(s/4096 + 1/2). For example, a coefficient of -47 applied to 0.5 gives -23.
- R6: A rounded value above 524287 gives 524287. A rounded value below -524288 gives -524288.
- R7: The sample history moves only on cycles where `in_valid` is high. A gap of any length between samples leaves the results of later samples unchanged.
- R8: Between strobes, `dout` keeps the last result it showed. After a reset it keeps 0.
- R9: A unit impulse (4096) followed by zeros gives the results c0, c1, ..., c6, ..., c1, c0, which is symmetric about the centre tap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accepts `din` on this edge |
| din | input | 20 | Input sample, signed, 12 fractional bits |
| out_valid | output | 1 | `dout` carries a new result |
| dout | output | 20 | Filtered sample, signed, 12 fractional bits |

## Verification
The hardest condition to reach from the ports is clamping. Clamping needs thirteen consecutive accepted samples at full scale, each with the same sign as the coefficient it will meet, so that the absolute sum of the coefficients (about 1.07) exceeds unity. The bench feeds that sequence and its negation, with idle gaps placed in the middle of the window. This exercises saturation and the hold behaviour of the history together. Rounding ties are reached with a 0.5 impulse, which puts an exact half-LSB on every odd coefficient.

// File: rtl/symfir_lp.sv
module symfir_lp #(
  parameter int DW = 20,
  parameter int FRAC = 12,
  parameter int CW = 16,
  parameter int CFRAC = 12,
  parameter int TAPS = 13,
  parameter bit PRE_REG = 1'b1,
  parameter bit MUL_REG = 1'b1,
  parameter bit ACC_REG = 1'b1,
  parameter logic signed [CW-1:0] COEF [(TAPS+1)/2] =
    '{-16'sd18, -16'sd47, -16'sd21, 16'sd106, 16'sd520, 16'sd980, 16'sd1010}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] din,
  output logic                 out_valid,
  output logic signed [DW-1:0] dout
);
  localparam int NP  = (TAPS + 1) / 2;
  localparam bit ODD = (TAPS % 2) == 1;
  localparam int PW  = DW + 1;
  localparam int MW  = PW + CW;
  localparam int AW  = MW + $clog2(NP);
  localparam int LAT = 2 + int'(PRE_REG) + int'(MUL_REG) + NP * int'(ACC_REG);
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (CFRAC - 1);
  localparam logic signed [AW-1:0] YMAX = (AW'(1) <<< (DW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] YMIN = -(AW'(1) <<< (DW - 1));

  logic signed [DW-1:0] dl [TAPS];
  logic [LAT-1:0] vp;
  logic signed [AW-1:0] acc [NP];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) dl[i] <= '0;
    end else if (in_valid) begin
      dl[0] <= din;
      for (int i = 1; i < TAPS; i++) dl[i] <= dl[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vp <= '0;
    else     vp <= {vp[LAT-2:0], in_valid};
  end

  for (genvar k = 0; k < NP; k++) begin : g_slice
    logic signed [PW-1:0] pa, pq;
    logic signed [MW-1:0] pm, pmq, pd;
    logic signed [AW-1:0] pe, sum;

    if (ODD && k == NP - 1) begin : g_mid
      assign pa = {dl[k][DW-1], dl[k]};
    end else begin : g_pair
      assign pa = {dl[k][DW-1], dl[k]} + {dl[TAPS-1-k][DW-1], dl[TAPS-1-k]};
    end

    if (PRE_REG) begin : g_preq
      always_ff @(posedge clk) pq <= rst ? '0 : pa;
    end else begin : g_prec
      assign pq = pa;
    end

    assign pm = pq * COEF[k];

    if (MUL_REG) begin : g_mulq
      always_ff @(posedge clk) pmq <= rst ? '0 : pm;
    end else begin : g_mulc
      assign pmq = pm;
    end

    if (ACC_REG && k > 0) begin : g_bal
      logic signed [MW-1:0] bd [k];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int j = 0; j < k; j++) bd[j] <= '0;
        end else begin
          bd[0] <= pmq;
          for (int j = 1; j < k; j++) bd[j] <= bd[j-1];
        end
      end
      assign pd = bd[k-1];
    end else begin : g_nobal
      assign pd = pmq;
    end

    assign pe = AW'(pd);

    if (k == 0) begin : g_first
      assign sum = pe;
    end else begin : g_next
      assign sum = acc[k-1] + pe;
    end

    if (ACC_REG) begin : g_accq
      always_ff @(posedge clk) acc[k] <= rst ? '0 : sum;
    end else begin : g_accc
      assign acc[k] = sum;
    end
  end

  logic signed [AW-1:0] rnd, sh;
  logic signed [DW-1:0] ysat;
  assign rnd  = acc[NP-1] + HALF;
  assign sh   = rnd >>> CFRAC;
  assign ysat = (sh > YMAX) ? YMAX[DW-1:0] :
                (sh < YMIN) ? YMIN[DW-1:0] : sh[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst)              dout <= '0;
    else if (vp[LAT-2])   dout <= ysat;
  end

  assign out_valid = vp[LAT-1];
endmodule

// File: rtl/symfir_lp_chk.sv
module symfir_lp_chk #(
  parameter int DW = 20,
  parameter int LAT = 11
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [DW-1:0] dout,
  input logic signed [DW-1:0] dl_head,
  input logic signed [DW-1:0] dl_tail
);
  localparam int CNW = $clog2(LAT + 2) + 1;
  logic [CNW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CNW'(in_valid) - CNW'(out_valid);
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && dout == '0));

  // R2
  emit_owed_chk: assert property (@(posedge clk) disable iff (rst) out_valid |-> cnt != '0);

  // R2
  inflight_cap_chk: assert property (@(posedge clk) disable iff (rst) cnt <= CNW'(LAT));

  // R7
  hold_line_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(dl_head) && $stable(dl_tail)));

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(dout));
endmodule

bind symfir_lp symfir_lp_chk #(.DW(DW), .LAT(LAT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .dout(dout), .dl_head(dl[0]), .dl_tail(dl[TAPS-1])
);

// File: tb/sim_symfir_lp.sv
module sim_symfir_lp;
  localparam int LAT = 11;
  localparam longint YMX = 524287;
  localparam longint YMN = -524288;
  localparam int C [7] = '{-18, -47, -21, 106, 520, 980, 1010};

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic signed [19:0] din = '0;
  logic out_valid;
  logic signed [19:0] dout;

  always #10 clk = ~clk;

  symfir_lp u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .din(din),
                .out_valid(out_valid), .dout(dout));

  int checks = 0, errors = 0, t = 0;
  longint hist [13];
  bit ev [32];
  longint ex [32];
  longint last = 0;
  int unsigned seed = 32'h1234_5678;

  function automatic int hc(int k);
    return C[(k <= 6) ? k : 12 - k];
  endfunction

  function automatic longint model();
    longint s = 0;
    longint y;
    for (int k = 0; k < 13; k++) s += longint'(hc(k)) * hist[k];
    y = (s + 2048) >>> 12;
    if (y > YMX) y = YMX;
    if (y < YMN) y = YMN;
    return y;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0d actual %0d expected %0d", req, t, act, exp);
    end
  endtask

  task automatic step(bit v, longint x, bit r);
    @(negedge clk);
    t++;
    if (ev[t % 32]) begin
      chk("R2 strobe", longint'(out_valid), 1);
      chk("R3/R5/R6 value", longint'(dout), ex[t % 32]);
      last = ex[t % 32];
      ev[t % 32] = 1'b0;
    end else begin
      chk("R2 no strobe", longint'(out_valid), 0);
      chk("R1/R8 hold", longint'(dout), last);
    end
    rst = r;
    in_valid = v;
    din = 20'(x);
    if (r) begin
      for (int i = 0; i < 32; i++) ev[i] = 1'b0;
      for (int i = 0; i < 13; i++) hist[i] = 0;
      last = 0;
    end else if (v) begin
      for (int i = 12; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x;
      ex[(t + LAT) % 32] = model();
      ev[(t + LAT) % 32] = 1'b1;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0);
  endtask

  function automatic longint rnd20();
    seed = seed * 1103515245 + 12345;
    return longint'($signed(seed[27:8]));
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) ev[i] = 1'b0;
    for (int i = 0; i < 13; i++) hist[i] = 0;
    // R1: reset state
    for (int i = 0; i < 4; i++) step(1'b0, 0, 1'b1);
    idle(3);
    // R9, R3: unit impulse
    step(1'b1, 4096, 1'b0);
    for (int i = 0; i < 14; i++) step(1'b1, 0, 1'b0);
    idle(LAT + 2);
    // R9 direct: centre and edge values of impulse seen through model
    chk("R9 centre coef", longint'(hc(6)), 1010);
    // R5: half-scale impulse gives rounding ties; R4 fractional input
    step(1'b1, 2048, 1'b0);
    for (int i = 0; i < 13; i++) step(1'b1, 0, 1'b0);
    step(1'b1, 1, 1'b0);
    for (int i = 0; i < 13; i++) step(1'b1, 0, 1'b0);
    idle(LAT + 2);
    // R6: positive then negative saturation, R7 gaps inside window
    for (int i = 0; i < 13; i++) begin
      step(1'b1, (hc(i) >= 0) ? YMX : YMN, 1'b0);
      if (i == 5) idle(3);
    end
    for (int i = 0; i < 13; i++) begin
      step(1'b1, (hc(i) >= 0) ? YMN : YMX, 1'b0);
      if (i == 8) idle(2);
    end
    for (int i = 0; i < 13; i++) step(1'b1, 0, 1'b0);
    idle(LAT + 2);
    // R7: random samples with irregular gaps, R2 back-to-back
    for (int i = 0; i < 300; i++) begin
      step(1'b1, rnd20(), 1'b0);
      if (seed[30:29] == 2'b00) idle(int'(seed[3:0]) % 5 + 1);
    end
    // R1: reset with samples in flight
    step(1'b0, 0, 1'b1);
    step(1'b0, 0, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b1, rnd20(), 1'b0);
    // R8: idle hold after stream
    idle(LAT + 8);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule